// File: doc/BRIEF.md
# Two-Dimensional Parity Product Encoder

This block turns one data word into a protected codeword for a vertical link built from a group of through-silicon vias. The word is viewed as a grid of `ROWS` by `COLS` bits. Bit (i, j) of the grid is `in_data[i*COLS + j]`. The block forms an even-parity bit for every grid row and for every grid column. It also forms one corner bit that covers the whole word. It then lays all of these out as a `(ROWS+1)` by `(COLS+1)` flit that drives the via group.

The default grid is 8 by 8, which gives 64 data bits and an 81-bit codeword. The same source also elaborates for 2 by 2 and 4 by 4 grids. The flit is flattened row by row, so flit bit `row*(COLS+1) + col` holds grid position (row, col). Grid rows 0..ROWS-1 each carry their COLS data bits and then that row's parity bit. The last row carries the column parities and then the corner bit.

The parity core is purely combinational. With `OUT_REG=1` (the default), a register stage captures a codeword on every valid input and delays the valid flag by one cycle. With `OUT_REG=0`, the flit and the valid flag follow the inputs in the same cycle.

Top module: `pp_flit_encoder`

## Requirements
- R1: For each grid row i, flit bit `i*(COLS+1)+COLS` equals the XOR of `in_data[i*COLS +: COLS]`. This makes every flit row even parity.
- R2: For each column j, flit bit `ROWS*(COLS+1)+j` equals the XOR of data bits `in_data[i*COLS+j]` over all i. This makes every flit column even parity.
- R3: Flit bit `(ROWS+1)*(COLS+1)-1` (the corner bit) equals the XOR of all data bits.
- R4: Data bit `in_data[i*COLS+j]` appears unchanged at flit bit `i*(COLS+1)+j`.
- R5: With `OUT_REG=1`, `out_valid` in a cycle equals `in_valid` of the previous cycle. The flit encoded from a valid input appears in that same following cycle.
- R6: With `OUT_REG=1`, a cycle with `in_valid` low leaves `out_flit` unchanged.
- R7: With `OUT_REG=1`, a synchronous active-high `rst` clears `out_valid` to 0 and `out_flit` to all zeros at the next clock edge.
- R8: The XOR of the row parity bits, the XOR of the column parity bits and the corner bit are all equal.
- R9: With `OUT_REG=0`, `out_valid` equals `in_valid` and `out_flit` equals the encoding of the current `in_data` in the same cycle. This holds for a 2 by 2 grid as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies `in_data` |
| in_data | input | ROWS*COLS | Data word, grid bit (i,j) at index i*COLS+j |
| out_valid | output | 1 | Qualifies `out_flit` |
| out_flit | output | (ROWS+1)*(COLS+1) | Packed codeword, row-major |

## Verification
In the registered configuration, every result of an input presented in cycle t is due at the clock edge that ends cycle t. This covers the row parities, the column parities, the corner bit, the data positions and the valid flag. The same edge applies to a reset, which takes effect at the first edge where it is high. The bench drives inputs at the falling edge. A behavioural model updates at the rising edge, and the bench compares against it at the next falling edge, so each compare lands exactly one edge after the stimulus. The unregistered 2 by 2 instance has zero latency, so it is compared a short delay after the inputs change, before any clock edge.

// File: rtl/pp_pkg.sv
package pp_pkg;
  // Width of the packed codeword for a rows x cols data grid
  function automatic int flit_width(input int rows, input int cols);
    return (rows + 1) * (cols + 1);
  endfunction

  // Row-major position of grid cell (row, col) in the codeword
  function automatic int flit_pos(input int row, input int col, input int cols);
    return row * (cols + 1) + col;
  endfunction
endpackage

// File: rtl/pp_row_parity.sv
module pp_row_parity #(
  parameter int ROWS = 8,
  parameter int COLS = 8
) (
  input  logic [ROWS*COLS-1:0] data,
  output logic [ROWS-1:0]      row_par
);
  for (genvar i = 0; i < ROWS; i++) begin : g_row
    assign row_par[i] = ^data[i*COLS +: COLS];
  end
endmodule

// File: rtl/pp_col_parity.sv
module pp_col_parity #(
  parameter int ROWS = 8,
  parameter int COLS = 8
) (
  input  logic [ROWS*COLS-1:0] data,
  output logic [COLS-1:0]      col_par
);
  for (genvar j = 0; j < COLS; j++) begin : g_col
    always_comb begin
      col_par[j] = 1'b0;
      for (int i = 0; i < ROWS; i++) begin
        col_par[j] = col_par[j] ^ data[i*COLS + j];
      end
    end
  end
endmodule

// File: rtl/pp_flit_pack.sv
module pp_flit_pack
  import pp_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int FW  = (ROWS + 1) * (COLS + 1)
) (
  input  logic [ROWS*COLS-1:0] data,
  input  logic [ROWS-1:0]      row_par,
  input  logic [COLS-1:0]      col_par,
  output logic [FW-1:0]        flit
);
  for (genvar i = 0; i < ROWS; i++) begin : g_row
    for (genvar j = 0; j < COLS; j++) begin : g_cell
      assign flit[flit_pos(i, j, COLS)] = data[i*COLS + j];
    end
    assign flit[flit_pos(i, COLS, COLS)] = row_par[i];
  end
  for (genvar j = 0; j < COLS; j++) begin : g_last
    assign flit[flit_pos(ROWS, j, COLS)] = col_par[j];
  end
  // Corner bit: XOR of all row parities equals XOR of all data bits
  assign flit[flit_pos(ROWS, COLS, COLS)] = ^row_par;
endmodule

// File: rtl/pp_out_reg.sv
module pp_out_reg #(
  parameter int W = 81
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         d_valid,
  input  logic [W-1:0] d_flit,
  output logic         q_valid,
  output logic [W-1:0] q_flit
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_flit  <= '0;
    end else begin
      q_valid <= d_valid;
      if (d_valid) q_flit <= d_flit;
    end
  end

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
    d_valid == 1'b1 |=> q_valid == 1'b1); // R5
  AST_IDLE_CLEARS_VALID: assert property (@(posedge clk) disable iff (rst)
    d_valid == 1'b0 |=> q_valid == 1'b0); // R5
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !d_valid |=> $stable(q_flit)); // R6
endmodule

// File: rtl/pp_flit_encoder.sv
module pp_flit_encoder
  import pp_pkg::*;
#(
  parameter int ROWS    = 8,
  parameter int COLS    = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           in_valid,
  input  logic [ROWS*COLS-1:0]           in_data,
  output logic                           out_valid,
  output logic [(ROWS+1)*(COLS+1)-1:0]   out_flit
);
  localparam int FW = flit_width(ROWS, COLS);

  logic [ROWS-1:0] row_par;
  logic [COLS-1:0] col_par;
  logic [FW-1:0]   flit_c;

  pp_row_parity #(.ROWS(ROWS), .COLS(COLS)) u_rows (
    .data(in_data), .row_par(row_par));

  pp_col_parity #(.ROWS(ROWS), .COLS(COLS)) u_cols (
    .data(in_data), .col_par(col_par));

  pp_flit_pack #(.ROWS(ROWS), .COLS(COLS)) u_pack (
    .data(in_data), .row_par(row_par), .col_par(col_par), .flit(flit_c));

  if (OUT_REG) begin : g_reg
    pp_out_reg #(.W(FW)) u_oreg (
      .clk(clk), .rst(rst),
      .d_valid(in_valid), .d_flit(flit_c),
      .q_valid(out_valid), .q_flit(out_flit));
  end else begin : g_comb
    assign out_valid = in_valid;
    assign out_flit  = flit_c;
  end

  // Row and column sums of the emitted codeword must be even
  for (genvar i = 0; i < ROWS; i++) begin : g_rchk
    AST_ROW_EVEN: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (^out_flit[i*(COLS+1) +: COLS+1]) == 1'b0); // R1
  end
  for (genvar j = 0; j <= COLS; j++) begin : g_cchk
    logic col_sum;
    always_comb begin
      col_sum = 1'b0;
      for (int i = 0; i <= ROWS; i++) col_sum = col_sum ^ out_flit[i*(COLS+1) + j];
    end
    AST_COL_EVEN: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> col_sum == 1'b0); // R2
  end

  AST_CORNER_AGREE: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> (^row_par) == (^col_par)); // R8
endmodule

// File: tb/sim_pp_flit_encoder.sv
module sim_pp_flit_encoder;
  localparam int M  = 8;
  localparam int N  = 8;
  localparam int FW = (M + 1) * (N + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [M*N-1:0] in_data = '0;
  logic out_valid;
  logic [FW-1:0] out_flit;
  logic c_valid;
  logic [8:0] c_flit;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  pp_flit_encoder #(.ROWS(M), .COLS(N), .OUT_REG(1'b1)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_flit(out_flit));

  // 2 x 2 unregistered variant
  pp_flit_encoder #(.ROWS(2), .COLS(2), .OUT_REG(1'b0)) u1 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data[3:0]),
    .out_valid(c_valid), .out_flit(c_flit));

  function automatic logic [80:0] enc(int m, int n, logic [63:0] d);
    logic [80:0] f = '0;
    for (int r = 0; r < m; r++) begin
      for (int c = 0; c < n; c++) begin
        f[r*(n+1)+c] = d[r*n+c];
        f[r*(n+1)+n] ^= d[r*n+c];
        f[m*(n+1)+c] ^= d[r*n+c];
        f[m*(n+1)+n] ^= d[r*n+c];
      end
    end
    return f;
  endfunction

  // kind: 1 data, 2 row parity, 3 column parity, 4 corner
  function automatic logic [80:0] fmask(int m, int n, int kind);
    logic [80:0] k = '0;
    for (int r = 0; r <= m; r++) begin
      for (int c = 0; c <= n; c++) begin
        if (kind == 1 && r < m && c < n) k[r*(n+1)+c] = 1'b1;
        if (kind == 2 && r < m && c == n) k[r*(n+1)+c] = 1'b1;
        if (kind == 3 && r == m && c < n) k[r*(n+1)+c] = 1'b1;
        if (kind == 4 && r == m && c == n) k[r*(n+1)+c] = 1'b1;
      end
    end
    return k;
  endfunction

  task automatic cmp(string req, logic [80:0] got, logic [80:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Behavioural reference for the registered instance
  logic          m_valid = 1'b0;
  logic [80:0]   m_flit  = '0;
  logic          p_rst   = 1'b1;
  logic          p_valid = 1'b0;
  always @(posedge clk) begin
    p_rst   <= rst;
    p_valid <= in_valid;
    if (rst) begin
      m_valid <= 1'b0;
      m_flit  <= '0;
    end else begin
      m_valid <= in_valid;
      if (in_valid) m_flit <= enc(M, N, in_data);
    end
  end

  task automatic check_u0();
    logic [80:0] got = 81'(out_flit);
    logic rx, cx;
    if (p_rst) begin
      cmp("R7 valid", 81'(out_valid), 81'(1'b0));
      cmp("R7 flit", got, '0);
      return;
    end
    cmp("R5 valid", 81'(out_valid), 81'(m_valid));
    if (!p_valid) begin
      cmp("R6 held flit", got, m_flit);
    end else begin
      cmp("R4 data", got & fmask(M, N, 1), m_flit & fmask(M, N, 1));
      cmp("R1 row parity", got & fmask(M, N, 2), m_flit & fmask(M, N, 2));
      cmp("R2 column parity", got & fmask(M, N, 3), m_flit & fmask(M, N, 3));
      cmp("R3 corner", got & fmask(M, N, 4), m_flit & fmask(M, N, 4));
      rx = ^(got & fmask(M, N, 2));
      cx = ^(got & fmask(M, N, 3));
      cmp("R8 row xor vs corner", 81'(rx), 81'(got[FW-1]));
      cmp("R8 column xor vs corner", 81'(cx), 81'(got[FW-1]));
    end
  endtask

  task automatic step(logic v, logic [63:0] d);
    @(negedge clk);
    check_u0();
    in_valid = v;
    in_data  = d;
    #1;
    if (!rst) begin
      cmp("R9 valid", 81'(c_valid), 81'(v));
      cmp("R9 flit", 81'(c_flit), enc(2, 2, {60'd0, d[3:0]}));
    end
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) step(1'b1, 64'hDEAD_BEEF_0123_4567);
    rst = 1'b0;
    step(1'b1, 64'h0);
    step(1'b1, '1);
    step(1'b1, 64'hAAAA_AAAA_AAAA_AAAA);
    step(1'b1, 64'h5555_5555_5555_5555);
    for (int k = 0; k < 64; k++) step(1'b1, 64'd1 << k); // single bits, all cells
    step(1'b1, 64'hFF00_FF00_FF00_FF00);
    step(1'b0, 64'h1234_5678_9ABC_DEF0); // ignored: R6
    step(1'b0, '1);
    step(1'b1, 64'h0F0F_0F0F_0F0F_0F0F);
    for (int k = 0; k < 100; k++) step(k % 3 != 0, {$urandom, $urandom});
    rst = 1'b1;
    step(1'b1, 64'hCAFE_F00D_CAFE_F00D); // reset mid-stream: R7
    rst = 1'b0;
    step(1'b1, 64'h8000_0000_0000_0001);
    for (int k = 0; k < 20; k++) step(1'b1, {$urandom, $urandom});
    step(1'b0, 64'h0);
    step(1'b0, 64'h0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule